// File: doc/BRIEF.md
# Two-Level ALU With Operation Decoder

This block is the arithmetic unit of a simple single-issue processor datapath, together with the small decoder that chooses its operation. The main instruction decoder supplies a 2-bit operation class. For register-register instructions the decoder also looks at the 6-bit function field of the instruction. From these two inputs it forms a 3-bit operation select. The arithmetic unit applies that select to two operands and returns a result, plus a flag that is high when the result is zero. The branch-equal path uses this flag.

The whole block is combinational. The decoder can be built in one of two ways, chosen by a parameter. The default is a complete lookup, which also gives defined behaviour for unused inputs. The other is a set of three minimized gate equations, which are only specified for legal inputs. The arithmetic unit uses one shared adder for addition, subtraction and the signed less-than test.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00 (memory access), the select output is 010 and the result is A + B modulo 2^WIDTH, whatever the function field holds.
- R2: With operation class 01 (branch compare), the select output is 110 and the result is A − B modulo 2^WIDTH, whatever the function field holds.
- R3: With operation class 10 (register format), the function field selects the operation: 100000 gives 010, 100010 gives 110, 100100 gives 000, 100101 gives 001 and 101010 gives 111.
- R4: Select 000 returns the bitwise AND of A and B. Select 001 returns the bitwise OR.
- R5: Addition and subtraction wrap modulo 2^WIDTH. A carry or borrow out of the top bit is discarded.
- R6: Select 111 returns 1 in bit 0 when A is less than B as two's-complement signed numbers, including the cases where A − B overflows, and 0 otherwise. Every bit above bit 0 is 0.
- R7: The zero output is 1 exactly when every bit of the result is 0.
- R8: With the lookup decoder (DECODE_STYLE = 0), operation class 11 gives select 010 (add), and so does class 10 with any function code not listed in R3.
- R9: With the gate-equation decoder (DECODE_STYLE = 1), the select and the result equal those of the lookup decoder for every legal class and function pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluop_i | input | 2 | Operation class from the main decoder |
| funct_i | input | 6 | Function field of the instruction |
| src_a_i | input | WIDTH | First operand |
| src_b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| op_sel_o | output | 3 | Decoded operation select |

## Verification
The hardest cases to reach are the signed less-than results where the subtraction overflows. There, the sign bit of the difference gives the wrong answer, and only the overflow correction saves it. The stimulus reaches these cases with operand pairs placed at opposite ends of the signed range, in both orders. Each such pair is driven under every legal class and function pair. A second instance built with the gate-equation decoder runs in parallel, so the two decoder variants are compared on exactly these patterns.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   localparam logic [1:0] CLS_MEM    = 2'b00;
   localparam logic [1:0] CLS_BRANCH = 2'b01;
   localparam logic [1:0] CLS_REG    = 2'b10;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   localparam int DEC_TABLE = 0;
   localparam int DEC_GATES = 1;

endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
   import alu_pkg::*;
#(
   parameter int DECODE_STYLE = DEC_TABLE
) (
   input  logic [1:0] aluop_i,
   input  logic [5:0] funct_i,
   output logic [2:0] op_o
);

   generate
      if (DECODE_STYLE != DEC_TABLE && DECODE_STYLE != DEC_GATES) begin : g_bad_style
         $error("alu_ctrl_dec: DECODE_STYLE must be 0 or 1");
      end

      if (DECODE_STYLE == DEC_GATES) begin : g_gates
         // Minimized equations, specified only for legal inputs
         assign op_o[2] = aluop_i[0] | (aluop_i[1] & funct_i[1]);
         assign op_o[1] = ~(aluop_i[1] & funct_i[2]);
         assign op_o[0] = aluop_i[1] & (funct_i[3] | funct_i[0]);
      end else begin : g_table
         alu_op_e sel;
         always_comb begin
            sel = ALU_ADD;
            case (aluop_i)
               CLS_MEM:    sel = ALU_ADD;
               CLS_BRANCH: sel = ALU_SUB;
               CLS_REG: begin
                  case (funct_i)
                     FN_ADD:  sel = ALU_ADD;
                     FN_SUB:  sel = ALU_SUB;
                     FN_AND:  sel = ALU_AND;
                     FN_OR:   sel = ALU_OR;
                     FN_SLT:  sel = ALU_SLT;
                     default: sel = ALU_ADD;
                  endcase
               end
               default:    sel = ALU_ADD;
            endcase
         end
         assign op_o = sel;
      end
   endgenerate

endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
   parameter int WIDTH = 32,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] data_i,
   output logic             zero_o
);

   localparam int NGRP  = (WIDTH + GROUP - 1) / GROUP;
   localparam int PADW  = NGRP * GROUP;

   logic [PADW-1:0] padded;
   logic [NGRP-1:0] grp_any;

   generate
      if (GROUP < 1) begin : g_bad_group
         $error("alu_zero_det: GROUP must be at least 1");
      end

      if (PADW == WIDTH) begin : g_exact
         assign padded = data_i;
      end else begin : g_pad
         assign padded = {{(PADW-WIDTH){1'b0}}, data_i};
      end

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |padded[g*GROUP +: GROUP];
      end
   endgenerate

   assign zero_o = ~(|grp_any);

endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH = 32
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o
);

   localparam int MSB = WIDTH - 1;

   logic             negate;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             ovf;
   logic             less;

   // op[2] selects subtract: invert B and inject a carry
   assign negate = op_i[2];
   assign b_eff  = negate ? ~b_i : b_i;
   assign sum    = a_i + b_eff + {{(WIDTH-1){1'b0}}, negate};

   // Signed overflow of the shared adder corrects the sign for less-than
   assign ovf  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
   assign less = sum[MSB] ^ ovf;

   always_comb begin
      case (op_i[1:0])
         2'b00:   y_o = a_i & b_i;
         2'b01:   y_o = a_i | b_i;
         2'b10:   y_o = sum;
         default: y_o = {{(WIDTH-1){1'b0}}, less};
      endcase
   end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int DECODE_STYLE = DEC_TABLE,
   parameter int ZERO_GROUP   = 4
) (
   input  logic [1:0]       aluop_i,
   input  logic [5:0]       funct_i,
   input  logic [WIDTH-1:0] src_a_i,
   input  logic [WIDTH-1:0] src_b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic [2:0]       op_sel_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [2:0]       op_sel;
   logic [WIDTH-1:0] result;

   alu_ctrl_dec #(
      .DECODE_STYLE(DECODE_STYLE)
   ) u_dec (
      .aluop_i(aluop_i),
      .funct_i(funct_i),
      .op_o   (op_sel)
   );

   alu_core #(
      .WIDTH(WIDTH)
   ) u_core (
      .op_i(op_sel),
      .a_i (src_a_i),
      .b_i (src_b_i),
      .y_o (result)
   );

   alu_zero_det #(
      .WIDTH(WIDTH),
      .GROUP(ZERO_GROUP)
   ) u_zero (
      .data_i(result),
      .zero_o(zero_o)
   );

   assign result_o = result;
   assign op_sel_o = op_sel;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
   parameter int WIDTH        = 32,
   parameter int DECODE_STYLE = 0
) (
   input logic [1:0]       aluop_i,
   input logic [5:0]       funct_i,
   input logic [WIDTH-1:0] src_a_i,
   input logic [WIDTH-1:0] src_b_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o,
   input logic [2:0]       op_sel_o
);

   always_comb begin
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag mismatch"); // R7
      AST_SLT_UPPER_CLEAR: assert (op_sel_o != 3'b111 || result_o[WIDTH-1:1] == '0) else $error("slt upper bits set"); // R6
      AST_MEM_ADD: assert (aluop_i != 2'b00 || op_sel_o == 3'b010) else $error("class 00 not add"); // R1
      AST_BRANCH_SUB: assert (aluop_i != 2'b01 || op_sel_o == 3'b110) else $error("class 01 not sub"); // R2
      AST_SEL_LEGAL: assert (DECODE_STYLE != 0 || op_sel_o inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111}) else $error("illegal select"); // R8
      AST_AND_RESULT: assert (op_sel_o != 3'b000 || result_o == (src_a_i & src_b_i)) else $error("and result"); // R4
   end

endmodule

bind alu_unit alu_unit_chk #(
   .WIDTH       (WIDTH),
   .DECODE_STYLE(DECODE_STYLE)
) u_chk (
   .aluop_i (aluop_i),
   .funct_i (funct_i),
   .src_a_i (src_a_i),
   .src_b_i (src_b_i),
   .result_o(result_o),
   .zero_o  (zero_o),
   .op_sel_o(op_sel_o)
);

// File: tb/alu_unit_test.sv
module alu_unit_test;

   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [1:0]   aluop;
   logic [5:0]   funct;
   logic [W-1:0] a, b;
   logic [W-1:0] res_t, res_g;
   logic         zero_t, zero_g;
   logic [2:0]   sel_t, sel_g;

   alu_unit #(.WIDTH(W), .DECODE_STYLE(0)) uut (
      .aluop_i(aluop), .funct_i(funct), .src_a_i(a), .src_b_i(b),
      .result_o(res_t), .zero_o(zero_t), .op_sel_o(sel_t));

   alu_unit #(.WIDTH(W), .DECODE_STYLE(1)) uut_gate (
      .aluop_i(aluop), .funct_i(funct), .src_a_i(a), .src_b_i(b),
      .result_o(res_g), .zero_o(zero_g), .op_sel_o(sel_g));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int cycles = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference: expected select code for the lookup decoder
   function automatic logic [2:0] ref_sel(input logic [1:0] cls, input logic [5:0] fn);
      if (cls == 2'b01) return 3'b110;
      if (cls != 2'b10) return 3'b010;
      if (fn == 6'b100010) return 3'b110;
      if (fn == 6'b100100) return 3'b000;
      if (fn == 6'b100101) return 3'b001;
      if (fn == 6'b101010) return 3'b111;
      return 3'b010;
   endfunction

   function automatic logic [W-1:0] ref_res(input logic [2:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
      longint sx, sy;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      if (s == 3'b000) return x & y;
      if (s == 3'b001) return x | y;
      if (s == 3'b110) return W'((longint'(x) - longint'(y)) & 64'hFFFF_FFFF);
      if (s == 3'b111) return (sx < sy) ? W'(1) : W'(0);
      return W'((longint'(x) + longint'(y)) & 64'hFFFF_FFFF);
   endfunction

   function automatic string tag_of(input logic [2:0] s);
      if (s == 3'b000 || s == 3'b001) return "R4";
      if (s == 3'b111) return "R6";
      return "R5";
   endfunction

   logic [W-1:0] opa [10] = '{32'd5, 32'd3, 32'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'hA5A5_A5A5, 32'h1234_5678, 32'h8000_0000, 32'hFFFF_FFFF};
   logic [W-1:0] opb [10] = '{32'd3, 32'd5, 32'd0, 32'd1, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h5A5A_5A5A, 32'h1234_5678, 32'd1, 32'hFFFF_FFFE};

   task automatic apply(input logic [1:0] cls, input logic [5:0] fn,
                        input logic [W-1:0] x, input logic [W-1:0] y,
                        input bit legal, input string ctag);
      logic [2:0]   es;
      logic [W-1:0] er;
      @(posedge clk);
      aluop = cls; funct = fn; a = x; b = y;
      @(negedge clk);
      es = ref_sel(cls, fn);
      er = ref_res(es, x, y);
      chk(sel_t == es, ctag, "select", longint'(sel_t), longint'(es));
      chk(res_t == er, tag_of(es), "result", longint'(res_t), longint'(er));
      chk(zero_t == (er == '0), "R7", "zero", longint'(zero_t), longint'(er == '0));
      if (legal) begin
         chk(sel_g == es, "R9", "gate select", longint'(sel_g), longint'(es));
         chk(res_g == er, "R9", "gate result", longint'(res_g), longint'(er));
      end
   endtask

   logic [5:0] legal_fn [5]   = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
   logic [5:0] any_fn [4]     = '{6'b000000, 6'b100100, 6'b101010, 6'b111111};
   logic [5:0] unknown_fn [4] = '{6'b000000, 6'b100001, 6'b111111, 6'b101011};

   initial begin
      aluop = 2'b00; funct = 6'b0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Idle state: add of zeros
      chk(res_t == '0, "R7", "idle result", longint'(res_t), 0);
      chk(zero_t == 1'b1, "R7", "idle zero", longint'(zero_t), 1);
      chk(sel_t == 3'b010, "R1", "idle select", longint'(sel_t), 2);

      for (int i = 0; i < 10; i++) begin
         for (int f = 0; f < 4; f++) begin
            apply(2'b00, any_fn[f], opa[i], opb[i], 1'b1, "R1");
            apply(2'b01, any_fn[f], opa[i], opb[i], 1'b1, "R2");
         end
         for (int f = 0; f < 5; f++)
            apply(2'b10, legal_fn[f], opa[i], opb[i], 1'b1, "R3");
         for (int f = 0; f < 4; f++) begin
            apply(2'b10, unknown_fn[f], opa[i], opb[i], 1'b0, "R8");
            apply(2'b11, unknown_fn[f], opa[i], opb[i], 1'b0, "R8");
         end
      end

      // Directed signed-overflow corners for less-than
      apply(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, 1'b1, "R6");
      chk(res_t == 32'd1, "R6", "min < 1", longint'(res_t), 1);
      apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
      chk(res_t == 32'd0, "R6", "max < -1", longint'(res_t), 0);
      apply(2'b01, 6'b000000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R5");
      chk(res_t == 32'd1, "R5", "0 - (-1) wraps", longint'(res_t), 1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule